// File: doc/BRIEF.md
# DRAM Power-Up and CAS-Before-RAS Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and then keeps its contents alive without an external row address counter. After reset it waits out a long settling pause, then runs a fixed number of warm-up refresh cycles and only then raises a ready flag. From that point on, an interval timer asks for one refresh per programmed period, so that every row of the array is refreshed within the retention window. The default settings give 2048 refreshes per 32 ms, which is one refresh about every 15.6 us.

Each refresh uses the CAS-before-RAS form. The block raises a request and holds it until the memory controller grants the bus. It then pulls CAS low, pulls RAS low a set number of cycles later, and keeps WE high for the whole cycle. Both strobes then return high for the precharge time, and busy falls only when that time has elapsed. A request that the controller cannot serve on time is not lost. It is counted in a small backlog counter, and backlog entries are served back to back once the controller grants them.

All durations are parameters counted in clock cycles. The defaults assume a 100 MHz clock: a 20000-cycle pause, 8 warm-up cycles, a 1560-cycle interval, 1 cycle of CAS lead, 6 cycles of RAS low and 4 cycles of precharge.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is held, and directly after it, ras_n_o, cas_n_o and we_n_o are 1 and req_o, ready_o and busy_o are 0.
- R2: req_o stays 0 during the power-up pause. It first goes to 1 after exactly PAUSE_CYC clock edges following reset release.
- R3: A grant is taken only when req_o and grant_i are both 1 at a clock edge while the block is idle. After that edge cas_n_o is 0 and ras_n_o is still 1 for CAS_LEAD_CYC cycles, so CAS falls before RAS.
- R4: ras_n_o then stays 0 for exactly RAS_LOW_CYC cycles, with cas_n_o held at 0 for that whole time. Both strobes return to 1 on the same edge.
- R5: we_n_o is 1 in every cycle, so a refresh cycle is never taken as a write.
- R6: After the strobes rise, busy_o stays 1 for PRECH_CYC more cycles. busy_o is therefore 1 for exactly CAS_LEAD_CYC+RAS_LOW_CYC+PRECH_CYC cycles per refresh.
- R7: Once raised, req_o stays 1 until it is granted. It is 0 in the cycle after the grant edge and stays 0 while busy_o is 1.
- R8: ready_o is 0 until the WARMUP_CNT-th warm-up refresh has finished its precharge. It rises on the same edge on which busy_o falls for that refresh, and it then stays 1.
- R9: Once ready_o is 1, one refresh request is added every REF_INTERVAL cycles. The first is visible REF_INTERVAL edges after ready_o rises, and the next ones follow at fixed REF_INTERVAL spacing whatever the grant timing.
- R10: Requests that are not yet served build up to at most 2**BACKLOG_W-1. With grant held at 1 they are served back to back, each one idle cycle after the previous. Requests arriving while the backlog is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Bus granted by the memory controller |
| ras_n_o | output | 1 | Row strobe to the DRAM, active low |
| cas_n_o | output | 1 | Column strobe to the DRAM, active low |
| we_n_o | output | 1 | Write enable to the DRAM, held high |
| req_o | output | 1 | Refresh wanted, held until granted |
| ready_o | output | 1 | Initialization complete, normal access allowed |
| busy_o | output | 1 | Refresh cycle owns the strobes |

## Verification
The assertions assume that grant_i is a plain level and that the controller never takes the strobes back while busy_o is 1. They also assume that grant_i has no meaning unless req_o is 1. The bench raises grant_i for one cycle only when it wants a single refresh, and holds it high only when it wants to drain the backlog. It changes grant_i at the falling clock edge, so a grant edge is never ambiguous. The backlog test waits a full set of intervals without granting, which pushes the counter to saturation and exercises the request-hold property over a long stretch.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_PRECH  = 2'd3
  } cbr_state_e;
endpackage

// File: rtl/cbr_pause_timer.sv
module cbr_pause_timer #(
  parameter int unsigned PAUSE_CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned PW = (PAUSE_CYC < 2) ? 1 : $clog2(PAUSE_CYC);
  localparam logic [PW-1:0] LAST = PW'(PAUSE_CYC - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (cnt_q == LAST) done_o <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_PAUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R2
endmodule

// File: rtl/cbr_warmup_ctr.sv
module cbr_warmup_ctr #(
  parameter int unsigned WARMUP_CNT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_done_i,
  output logic ready_o
);
  localparam int unsigned WW = $clog2(WARMUP_CNT + 1);
  localparam logic [WW-1:0] LAST = WW'(WARMUP_CNT - 1);

  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_o <= 1'b0;
    end else if (cyc_done_i && !ready_o) begin
      if (cnt_q == LAST) ready_o <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R8
endmodule

// File: rtl/cbr_interval_ctr.sv
module cbr_interval_ctr #(
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned BACKLOG_W    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic dec_i,
  output logic pending_o
);
  localparam int unsigned IW = (REF_INTERVAL < 2) ? 1 : $clog2(REF_INTERVAL);
  localparam logic [IW-1:0] LAST = IW'(REF_INTERVAL - 1);
  localparam logic [BACKLOG_W-1:0] PMAX = '1;

  logic [IW-1:0]        tmr_q;
  logic [BACKLOG_W-1:0] pend_q;
  logic                 tick;

  assign tick = run_i && (tmr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (!run_i) tmr_q <= '0;
    else if (tick)   tmr_q <= '0;
    else             tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (tick && !dec_i) begin
      if (pend_q != PMAX) pend_q <= pend_q + 1'b1;
    end else if (dec_i && !tick) begin
      pend_q <= pend_q - 1'b1;
    end
  end

  assign pending_o = (pend_q != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == PMAX && tick && !dec_i) |=> (pend_q == PMAX)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (pend_q != '0)); // R9
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import cbr_pkg::*;
#(
  parameter int unsigned CAS_LEAD_CYC = 1,
  parameter int unsigned RAS_LOW_CYC  = 6,
  parameter int unsigned PRECH_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned M1   = (CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC;
  localparam int unsigned MAXD = (M1 > PRECH_CYC) ? M1 : PRECH_CYC;
  localparam int unsigned CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
  localparam logic [CW-1:0] LEAD_L = CW'(CAS_LEAD_CYC - 1);
  localparam logic [CW-1:0] RAS_L  = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] PRE_L  = CW'(PRECH_CYC - 1);

  cbr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_SETUP;
          cnt_q <= LEAD_L;
        end
        ST_SETUP: if (cnt_q == '0) begin
          st_q  <= ST_STROBE;
          cnt_q <= RAS_L;
        end else cnt_q <= cnt_q - 1'b1;
        ST_STROBE: if (cnt_q == '0) begin
          st_q  <= ST_PRECH;
          cnt_q <= PRE_L;
        end else cnt_q <= cnt_q - 1'b1;
        ST_PRECH: if (cnt_q == '0) st_q <= ST_IDLE;
                  else cnt_q <= cnt_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == ST_IDLE);
  assign done_o  = (st_q == ST_PRECH) && (cnt_q == '0);
  assign cas_n_o = !((st_q == ST_SETUP) || (st_q == ST_STROBE));
  assign ras_n_o = !(st_q == ST_STROBE);

  AST_CAS_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> $past(!cas_n_o)); // R3
  AST_CAS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> (ras_n_o && $past(!ras_n_o))); // R4
  AST_RAS_UNDER_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o); // R4
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned WARMUP_CNT   = 8,
  parameter int unsigned REF_INTERVAL = 1560,
  parameter int unsigned CAS_LEAD_CYC = 1,
  parameter int unsigned RAS_LOW_CYC  = 6,
  parameter int unsigned PRECH_CYC    = 4,
  parameter int unsigned BACKLOG_W    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic req_o,
  output logic ready_o,
  output logic busy_o
);
  logic pause_done;
  logic eng_idle;
  logic eng_done;
  logic has_pend;
  logic warm_need;
  logic start;

  cbr_pause_timer #(.PAUSE_CYC(PAUSE_CYC)) u_pause (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pause_done)
  );

  cbr_warmup_ctr #(.WARMUP_CNT(WARMUP_CNT)) u_warm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_done_i (eng_done),
    .ready_o    (ready_o)
  );

  cbr_interval_ctr #(
    .REF_INTERVAL (REF_INTERVAL),
    .BACKLOG_W    (BACKLOG_W)
  ) u_intv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ready_o),
    .dec_i     (start && ready_o),
    .pending_o (has_pend)
  );

  cbr_strobe_fsm #(
    .CAS_LEAD_CYC (CAS_LEAD_CYC),
    .RAS_LOW_CYC  (RAS_LOW_CYC),
    .PRECH_CYC    (PRECH_CYC)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .idle_o  (eng_idle),
    .done_o  (eng_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  assign warm_need = pause_done && !ready_o;
  assign req_o     = eng_idle && (warm_need || has_pend);
  assign start     = req_o && grant_i;
  assign busy_o    = !eng_idle;
  assign we_n_o    = 1'b1;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !grant_i) |=> req_o); // R7
  AST_NO_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o); // R7
  AST_GRANTED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_o && grant_i)); // R3
  AST_QUIET_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_done |-> (!req_o && !busy_o)); // R2
endmodule

// File: tb/sim_cbr_refresh_seq.sv
module sim_cbr_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P_PAUSE = 20;
  localparam int P_WARM  = 8;
  localparam int P_INT   = 30;
  localparam int P_LEAD  = 1;
  localparam int P_RAS   = 3;
  localparam int P_PRE   = 2;
  localparam int P_BW    = 2;
  localparam int TOT     = P_LEAD + P_RAS + P_PRE;
  localparam int PMAX    = (1 << P_BW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic grant = 1'b0;
  logic ras_n, cas_n, we_n, req, ready, busy;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int we_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cbr_refresh_seq #(
    .PAUSE_CYC(P_PAUSE), .WARMUP_CNT(P_WARM), .REF_INTERVAL(P_INT),
    .CAS_LEAD_CYC(P_LEAD), .RAS_LOW_CYC(P_RAS), .PRECH_CYC(P_PRE), .BACKLOG_W(P_BW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .grant_i(grant),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .req_o(req), .ready_o(ready), .busy_o(busy)
  );

  // R5 monitor
  always @(negedge clk) if (we_n !== 1'b1) we_err <= we_err + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one granted refresh; checks R3 R4 R6 R7 each cycle
  task automatic run_cbr(input bit more);
    logic [3:0] act, exp;
    grant = 1'b1;
    step();
    grant = 1'b0;
    for (int j = 1; j <= TOT + 1; j++) begin
      act = {ras_n, cas_n, busy, req};
      if (j <= TOT)
        exp = {!(j > P_LEAD && j <= P_LEAD + P_RAS), !(j <= P_LEAD + P_RAS), 1'b1, 1'b0};
      else
        exp = {1'b1, 1'b1, 1'b0, more};
      chk(act == exp, (j <= P_LEAD) ? "R3" : (j <= P_LEAD + P_RAS) ? "R4" : "R6",
          int'(act), int'(exp));
      if (j <= TOT) step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  initial begin
    int n;
    int t0;
    int runs;
    bit prev_cas;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n, req, ready, busy} == 6'b111000, "R1",
        {ras_n, cas_n, we_n, req, ready, busy}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, req, ready, busy} == 6'b111000, "R1",
        {ras_n, cas_n, we_n, req, ready, busy}, 6'b111000);
    n = 1;
    while (!req && n < 1000) begin
      step();
      n++;
    end
    chk(n == P_PAUSE, "R2", n, P_PAUSE);
    chk(!ready && !busy, "R8", {ready, busy}, 0);

    for (int k = 0; k < 5; k++) begin
      step();
      chk(req && !busy, "R7", {req, busy}, 2'b10);
    end

    for (int i = 0; i < P_WARM; i++) begin
      run_cbr(i < P_WARM - 1);
      chk(ready == (i == P_WARM - 1), "R8", ready, (i == P_WARM - 1));
    end

    n = 0;
    while (!req && n < 1000) begin
      step();
      n++;
    end
    chk(n == P_INT, "R9", n, P_INT);
    t0 = cyc;

    while (cyc != t0 + 4 * P_INT) @(negedge clk);
    chk(req && ready, "R9", {req, ready}, 2'b11);
    grant = 1'b1;
    runs = 0;
    prev_cas = cas_n;
    for (int k = 0; k < 60; k++) begin
      step();
      if (prev_cas && !cas_n) runs++;
      prev_cas = cas_n;
      if (!busy && !req) break;
    end
    grant = 1'b0;
    chk(runs == PMAX, "R10", runs, PMAX);
    chk(cyc < t0 + 5 * P_INT - 1, "R10", cyc, t0 + 5 * P_INT - 1);

    while (cyc != t0 + 5 * P_INT - 1) @(negedge clk);
    chk(!req, "R9", req, 0);
    @(negedge clk);
    chk(req, "R9", req, 1);
    run_cbr(1'b0);
    chk(ready, "R8", ready, 1);

    chk(we_err == 0, "R5", we_err, 0);

    rst_n = 1'b0;
    @(negedge clk);
    chk({ras_n, cas_n, we_n, req, ready, busy} == 6'b111000, "R1",
        {ras_n, cas_n, we_n, req, ready, busy}, 6'b111000);
    summary();
  end
endmodule